// File: doc/BRIEF.md
# External Bus Strobe and Chip-Enable Pin Multiplexer

This block drives six pins that a small microcontroller shares between its external memory bus and its general output ports. Four pins carry either an active-low chip enable or one bit of the "CE-side" output port. Two pins carry either the active-low read or write strobe, or one bit of the "strobe-side" output port. The bus mode input selects the role of each pin. In the three expanded modes, a per-pin software select also chooses between chip enable and port bit for the four chip-enable pins.

Each access is decoded into at most one chip-enable window, and the address map depends on the bus mode. In the 64K expanded mode, a range-layout input chooses the window size. An internal-memory hit suppresses all strobes and enables. A small cycle state machine registers each access. It moves between three named states:

- `CYC_IDLE`: no external access.
- `CYC_READ`: RD is low.
- `CYC_WRITE`: WR is low.

It re-decides the state on every clock edge:

- IDLE/READ/WRITE → READ on an external read request.
- → WRITE on an external write request with no read request.
- → IDLE otherwise, or on an internal hit, or in single-chip mode.

The strobes and enables therefore appear one cycle after the request. When a pin is in its bus role, its port data and high-impedance bits no longer reach the pin. They stay readable and writable on the register bus.

Top module: `ebus_pin_mux`

## Requirements
- R1: After reset, all four registers are cleared except the data registers, which read all ones. The register map is: address 0 = CE-side data (bits 3:0), 1 = CE-side high-impedance (bits 3:0), 2 = strobe-side data, 3 = strobe-side high-impedance. In the strobe-side registers, bit 0 belongs to the RD pin and bit 1 to the WR pin. The cycle state is idle.
- R2: In single-chip mode (bus_mode 00), every CE pin shows its port data bit whatever ce_sel holds, and no strobe or chip enable is ever asserted.
- R3: In an expanded mode (bus_mode 01, 10, 11), CE pin k carries the chip enable when ce_sel[k] is 1 and its port bit when ce_sel[k] is 0.
- R4: The RD and WR pins (rw_pin bit 0 and bit 1) are port bits in single-chip mode and strobes in every expanded mode.
- R5: A pin in its bus role has output enable 1. A pin in port role has output enable equal to the inverse of its high-impedance bit.
- R6: All four registers stay readable and writable whatever role their pins have. Bits above the implemented width read as 0.
- R7: An external read request drives RD low in the following cycle; an external write request drives WR low. A read request wins when both are raised, so RD and WR are never low together.
- R8: A request with int_hit set asserts no strobe and no chip enable.
- R9: In 64K mode, range layout k gives windows of 8K·2^k bytes starting at 0 on address bits 15:0. CE n covers window n. Addresses past the fourth window assert no CE.
- R10: In both 512K modes, CE n covers the 128K window selected by address bits 18:17 equal to n.
- R11: At most one chip enable is low in any cycle.
- R12: With no external access in progress, RD, WR and all chip enables idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 2 | 00 single-chip, 01 64K, 10/11 512K variants |
| ce_sel | input | 4 | Per-pin CE (1) or port (0) role in expanded modes |
| range_sel | input | 2 | Range layout for 64K mode |
| cpu_addr | input | 19 | CPU byte address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| int_hit | input | 1 | Access targets internal memory |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ce_pin_o | output | 4 | CE-side pin levels |
| ce_pin_oe | output | 4 | CE-side pin output enables |
| rw_pin_o | output | 2 | Strobe-side pin levels (bit 0 RD, bit 1 WR) |
| rw_pin_oe | output | 2 | Strobe-side pin output enables |

## Verification
A register-bus write to a port register can land in the same cycle as an external access on the very pin that register used to drive. The bench raises a read request and a write to the CE-side data register on the same clock edge. It then checks that the pin shows the chip enable, not the new data. It also checks that the register reads back the written value. Last, it switches to single-chip mode and checks that the stored value now appears on the pin.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [1:0] {
        BM_SINGLE   = 2'b00,
        BM_EXP64K   = 2'b01,
        BM_EXP512_A = 2'b10,
        BM_EXP512_B = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'b00,
        CYC_READ  = 2'b01,
        CYC_WRITE = 2'b10
    } cyc_state_e;

    localparam logic [1:0] RA_CE_DATA = 2'd0;
    localparam logic [1:0] RA_CE_HZ   = 2'd1;
    localparam logic [1:0] RA_RW_DATA = 2'd2;
    localparam logic [1:0] RA_RW_HZ   = 2'd3;

endpackage

// File: rtl/ebus_ce_decode.sv
module ebus_ce_decode
    import ebus_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int NUM_CE     = 4,
    parameter int SMALL_W    = 16,
    parameter int BASE_SHIFT = 13,
    parameter int BIG_SHIFT  = 17
) (
    input  bus_mode_e          mode,
    input  logic [1:0]         layout,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CE-1:0]  hit
);
    logic [ADDR_W-1:0] win_idx;
    logic              win_valid;

    always_comb begin
        win_idx   = '0;
        win_valid = 1'b0;
        unique case (mode)
            BM_EXP64K: begin
                win_idx   = ADDR_W'(addr[SMALL_W-1:0]) >> (BASE_SHIFT + int'(layout));
                win_valid = 1'b1;
            end
            BM_EXP512_A, BM_EXP512_B: begin
                win_idx   = addr >> BIG_SHIFT;
                win_valid = 1'b1;
            end
            default: begin
                win_idx   = '0;
                win_valid = 1'b0;
            end
        endcase
    end

    for (genvar k = 0; k < NUM_CE; k++) begin : g_win
        assign hit[k] = win_valid && (win_idx == ADDR_W'(k));
    end

endmodule

// File: rtl/ebus_cycle_fsm.sv
module ebus_cycle_fsm
    import ebus_pkg::*;
#(
    parameter int NUM_CE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              int_hit,
    input  logic [NUM_CE-1:0] ce_hit,
    output logic              rd_n,
    output logic              wr_n,
    output logic [NUM_CE-1:0] ce_n
);
    cyc_state_e        state_q, state_d;
    logic [NUM_CE-1:0] ce_q;
    logic              ext_ok;

    assign ext_ok = (mode != BM_SINGLE) && !int_hit;

    always_comb begin
        state_d = CYC_IDLE;
        unique case (state_q)
            CYC_IDLE, CYC_READ, CYC_WRITE: begin
                if (ext_ok && rd_req)      state_d = CYC_READ;
                else if (ext_ok && wr_req) state_d = CYC_WRITE;
                else                       state_d = CYC_IDLE;
            end
            default: state_d = CYC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            ce_q    <= '0;
        end else begin
            state_q <= state_d;
            ce_q    <= (state_d == CYC_IDLE) ? '0 : ce_hit;
        end
    end

    always_comb begin
        rd_n = 1'b1;
        wr_n = 1'b1;
        ce_n = '1;
        unique case (state_q)
            CYC_READ: begin
                rd_n = 1'b0;
                ce_n = ~ce_q;
            end
            CYC_WRITE: begin
                wr_n = 1'b0;
                ce_n = ~ce_q;
            end
            default: begin
                rd_n = 1'b1;
                wr_n = 1'b1;
                ce_n = '1;
            end
        endcase
    end

    p_rw_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    p_rd_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !int_hit && mode != BM_SINGLE) |=> !rd_n);
    p_int_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_hit && (rd_req || wr_req)) |=> (rd_n && wr_n && (&ce_n)));
    p_single_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BM_SINGLE) |=> (rd_n && wr_n && (&ce_n)));
    p_ce_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ce_n) <= 1);

endmodule

// File: rtl/ebus_port_regs.sv
module ebus_port_regs
    import ebus_pkg::*;
#(
    parameter int NUM_CE = 4,
    parameter int NUM_RW = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CE-1:0] ce_data,
    output logic [NUM_CE-1:0] ce_hz,
    output logic [NUM_RW-1:0] rw_data,
    output logic [NUM_RW-1:0] rw_hz
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^wdata[DATA_W-1:NUM_RW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_data <= '1;
            ce_hz   <= '0;
            rw_data <= '1;
            rw_hz   <= '0;
        end else if (we) begin
            unique case (addr)
                RA_CE_DATA: ce_data <= wdata[NUM_CE-1:0];
                RA_CE_HZ:   ce_hz   <= wdata[NUM_CE-1:0];
                RA_RW_DATA: rw_data <= wdata[NUM_RW-1:0];
                RA_RW_HZ:   rw_hz   <= wdata[NUM_RW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            RA_CE_DATA: rdata = DATA_W'(ce_data);
            RA_CE_HZ:   rdata = DATA_W'(ce_hz);
            RA_RW_DATA: rdata = DATA_W'(rw_data);
            default:    rdata = DATA_W'(rw_hz);
        endcase
    end

    p_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_CE_DATA) |=> (ce_data == $past(wdata[NUM_CE-1:0])));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(ce_data) && $stable(ce_hz) && $stable(rw_data) && $stable(rw_hz)));

endmodule

// File: rtl/ebus_pin_cell.sv
module ebus_pin_cell (
    input  logic bus_role,
    input  logic bus_level,
    input  logic port_data,
    input  logic port_hz,
    output logic pin_o,
    output logic pin_oe
);
    always_comb begin
        if (bus_role) begin
            pin_o  = bus_level;
            pin_oe = 1'b1;
        end else begin
            pin_o  = port_data;
            pin_oe = !port_hz;
        end
    end
endmodule

// File: rtl/ebus_pin_mux.sv
module ebus_pin_mux
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int NUM_CE = 4,
    parameter int NUM_RW = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_mode,
    input  logic [NUM_CE-1:0] ce_sel,
    input  logic [1:0]        range_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              int_hit,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CE-1:0] ce_pin_o,
    output logic [NUM_CE-1:0] ce_pin_oe,
    output logic [NUM_RW-1:0] rw_pin_o,
    output logic [NUM_RW-1:0] rw_pin_oe
);
    bus_mode_e         mode;
    logic [NUM_CE-1:0] ce_hit, ce_n, ce_data, ce_hz;
    logic [NUM_RW-1:0] rw_data, rw_hz, rw_level;
    logic              rd_n, wr_n, expanded;

    assign mode     = bus_mode_e'(bus_mode);
    assign expanded = (mode != BM_SINGLE);
    assign rw_level = {wr_n, rd_n};

    ebus_ce_decode #(.ADDR_W(ADDR_W), .NUM_CE(NUM_CE)) u_dec (
        .mode(mode), .layout(range_sel), .addr(cpu_addr), .hit(ce_hit)
    );

    ebus_cycle_fsm #(.NUM_CE(NUM_CE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rd_req(cpu_rd), .wr_req(cpu_wr),
        .int_hit(int_hit), .ce_hit(ce_hit), .rd_n(rd_n), .wr_n(wr_n), .ce_n(ce_n)
    );

    ebus_port_regs #(.NUM_CE(NUM_CE), .NUM_RW(NUM_RW), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .ce_data(ce_data), .ce_hz(ce_hz),
        .rw_data(rw_data), .rw_hz(rw_hz)
    );

    for (genvar k = 0; k < NUM_CE; k++) begin : g_ce_pin
        ebus_pin_cell u_cell (
            .bus_role(expanded && ce_sel[k]), .bus_level(ce_n[k]),
            .port_data(ce_data[k]), .port_hz(ce_hz[k]),
            .pin_o(ce_pin_o[k]), .pin_oe(ce_pin_oe[k])
        );
    end

    for (genvar j = 0; j < NUM_RW; j++) begin : g_rw_pin
        ebus_pin_cell u_cell (
            .bus_role(expanded), .bus_level(rw_level[j]),
            .port_data(rw_data[j]), .port_hz(rw_hz[j]),
            .pin_o(rw_pin_o[j]), .pin_oe(rw_pin_oe[j])
        );
    end

    p_bus_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expanded |-> (&rw_pin_oe));
    p_idle_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |=> (rd_n && wr_n && (&ce_n)));

endmodule

// File: tb/ebus_pin_mux_tb.sv
module ebus_pin_mux_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'b00;
    logic [3:0]  ce_sel = 4'h0;
    logic [1:0]  range_sel = 2'b00;
    logic [18:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, int_hit = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [3:0]  ce_pin_o, ce_pin_oe;
    logic [1:0]  rw_pin_o, rw_pin_oe;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ebus_pin_mux u_dut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .ce_sel(ce_sel),
        .range_sel(range_sel), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .int_hit(int_hit), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ce_pin_o(ce_pin_o), .ce_pin_oe(ce_pin_oe),
        .rw_pin_o(rw_pin_o), .rw_pin_oe(rw_pin_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Raise a request for one cycle; return at the negedge where its effect shows.
    task automatic access(input logic rd, input logic wr, input logic [18:0] a,
                          input logic ih);
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; int_hit = ih;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0; int_hit = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        reg_read(2'd0, d); check("R1", "ce data reset", d, 8'h0F);
        reg_read(2'd1, d); check("R1", "ce hz reset", d, 8'h00);
        reg_read(2'd2, d); check("R1", "rw data reset", d, 8'h03);
        reg_read(2'd3, d); check("R1", "rw hz reset", d, 8'h00);
        check("R1", "ce pins in single", {ce_pin_oe, ce_pin_o}, 8'hFF);
    endtask

    task automatic t_single;
        bus_mode = 2'b00; ce_sel = 4'hF;
        reg_write(2'd0, 8'h05);
        reg_write(2'd1, 8'h02);
        access(1'b1, 1'b0, 19'h0, 1'b0);
        check("R2", "ce pins o single", ce_pin_o, 4'b0101);
        check("R5", "ce pins oe single", ce_pin_oe, 4'b1101);
    endtask

    task automatic t_ce_select;
        bus_mode = 2'b01; range_sel = 2'b00; ce_sel = 4'b0101;
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h08);
        #1;
        check("R3", "mixed idle o", ce_pin_o, 4'b0101);
        check("R5", "mixed oe", ce_pin_oe, 4'b0111);
        check("R12", "idle ce high", ce_pin_o & 4'b0101, 4'b0101);
        access(1'b1, 1'b0, 19'h0, 1'b0);
        check("R3", "mixed CE0 low", ce_pin_o, 4'b0100);
    endtask

    task automatic t_strobe_role;
        bus_mode = 2'b00;
        reg_write(2'd2, 8'h02);
        reg_write(2'd3, 8'h01);
        #1;
        check("R4", "rw port o", rw_pin_o, 2'b10);
        check("R5", "rw port oe", rw_pin_oe, 2'b10);
        bus_mode = 2'b01; #1;
        check("R4", "rw strobe idle", rw_pin_o, 2'b11);
        check("R5", "rw strobe oe", rw_pin_oe, 2'b11);
        access(1'b1, 1'b0, 19'h0, 1'b0);
        check("R7", "read RD low", rw_pin_o, 2'b10);
        access(1'b0, 1'b1, 19'h0, 1'b0);
        check("R7", "write WR low", rw_pin_o, 2'b01);
        access(1'b1, 1'b1, 19'h0, 1'b0);
        check("R7", "read wins", rw_pin_o, 2'b10);
        @(negedge clk);
        check("R12", "back idle", rw_pin_o, 2'b11);
    endtask

    task automatic t_decode_64k;
        bus_mode = 2'b01; ce_sel = 4'hF;
        range_sel = 2'd0; access(1'b1, 1'b0, 19'h02000, 1'b0);
        check("R9", "L0 8K -> CE1", ce_pin_o, 4'b1101);
        range_sel = 2'd0; access(1'b1, 1'b0, 19'h08000, 1'b0);
        check("R9", "L0 past end", ce_pin_o, 4'b1111);
        range_sel = 2'd1; access(1'b0, 1'b1, 19'h0C000, 1'b0);
        check("R9", "L1 -> CE3", ce_pin_o, 4'b0111);
        range_sel = 2'd2; access(1'b1, 1'b0, 19'h09000, 1'b0);
        check("R9", "L2 -> CE1", ce_pin_o, 4'b1101);
        range_sel = 2'd3; access(1'b1, 1'b0, 19'h0FFFF, 1'b0);
        check("R9", "L3 -> CE0", ce_pin_o, 4'b1110);
        range_sel = 2'd0; access(1'b1, 1'b0, 19'h42000, 1'b0);
        check("R9", "upper bits ignored", ce_pin_o, 4'b1101);
    endtask

    task automatic t_decode_512k;
        ce_sel = 4'hF;
        bus_mode = 2'b10; access(1'b1, 1'b0, 19'h60000, 1'b0);
        check("R10", "512A -> CE3", ce_pin_o, 4'b0111);
        bus_mode = 2'b11; access(1'b0, 1'b1, 19'h3FFFF, 1'b0);
        check("R10", "512B -> CE1", ce_pin_o, 4'b1101);
        check("R11", "single CE low", 32'($countones(~ce_pin_o)), 32'd1);
    endtask

    task automatic t_internal;
        bus_mode = 2'b01; range_sel = 2'd0; ce_sel = 4'hF;
        access(1'b1, 1'b0, 19'h0, 1'b1);
        check("R8", "int read ce", ce_pin_o, 4'b1111);
        check("R8", "int read rw", rw_pin_o, 2'b11);
        access(1'b0, 1'b1, 19'h02000, 1'b1);
        check("R8", "int write rw", rw_pin_o, 2'b11);
    endtask

    task automatic t_concurrent;
        logic [7:0] d;
        bus_mode = 2'b01; range_sel = 2'd0; ce_sel = 4'hF;
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 19'h0;
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hF3;
        @(negedge clk);
        cpu_rd = 1'b0; reg_we = 1'b0;
        check("R3", "pin shows CE not data", ce_pin_o, 4'b1110);
        reg_read(2'd0, d);
        check("R6", "detached reg readback masked", d, 8'h03);
        reg_write(2'd3, 8'hFE);
        reg_read(2'd3, d);
        check("R6", "rw hz readback", d, 8'h02);
        bus_mode = 2'b00; #1;
        check("R2", "stored data reaches pin", ce_pin_o, 4'b0011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_ce_select();
        t_strobe_role();
        t_decode_64k();
        t_decode_512k();
        t_internal();
        t_concurrent();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule